// File: doc/BRIEF.md
# Two-Stage Decimating Low-Pass Filter

This block is one rail (in-phase or quadrature) of a baseband decimator that follows a complex mixer. Signed 16-bit samples enter at the high input rate under a valid strobe. A cascade of integrators and combs gives a sin(x)/x response and divides the rate by a run-time factor R. A short symmetric FIR then filters the result and keeps every second sample, so it sets the final passband and stopband edges. With R = 32, a 4 MSPS stream becomes 125 kSPS after the first stage and 62.5 kSPS at the output.

The FIR coefficients are signed 20-bit words. Because the impulse response is symmetric, only half of them are stored, and each stored word serves a mirrored pair of taps. A write port loads them into a shadow bank. The live bank follows the shadow bank while the filter is idle, and it is also refreshed by a flush. The full-precision FIR sum is scaled down by a fixed shift, rounded to nearest and clamped to a signed 24-bit result. A single-cycle valid marks each result. The overall decimation 2·R reaches 16384 with the default maximum rate.

Top module: `lp_decimator`

## Requirements
- R1: After reset, out_valid_o is 0 and out_data_o is 0.
- R2: For a constant input x held long enough to settle, every output equals round(x · R^ORDER · G / 2^SHIFT), where G is the sum of all TAPS coefficients.
- R3: Exactly one output is produced for every 2·R accepted input samples, counted from a flush, and out_valid_o is never high on two consecutive cycles.
- R4: The first-stage rate R is taken from rate_i, valid from 2 up to MAX_RATE, and it changes both the output spacing and the DC gain R^ORDER.
- R5: Coefficient address k (0 … TAPS/2−1) sets both tap k and tap TAPS−1−k, so G is twice the sum of the stored words.
- R6: Coefficient writes made after samples have started flowing do not change the output until the next flush.
- R7: A flush clears all filter state. On the cycle after it, out_valid_o is 0 and out_data_o is 0, and the latest written coefficients take effect.
- R8: Rounding is to nearest, with ties toward positive infinity (−0.5 becomes 0, −1.5 becomes −1, +0.5 becomes 1).
- R9: Results above 2^23−1 give 2^23−1, and results below −2^23 give −2^23.
- R10: The integrators wrap in two's complement, so results stay exact after any number of samples, even at full-scale input and maximum rate.
- R11: Cycles with in_valid_i low are ignored. Input gaps change neither the output values nor the number of outputs per sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Clear state and apply the shadow coefficients |
| rate_i | input | $clog2(MAX_RATE)+1 | First-stage decimation factor R |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | $clog2(TAPS/2) | Coefficient pair index |
| coef_data_i | input | COEF_W | Signed coefficient word |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | IN_W | Signed input sample |
| out_valid_o | output | 1 | One-cycle pulse per output sample |
| out_data_o | output | OUT_W | Rounded, saturated signed output |

## Verification
The bench builds the block with a third-order first stage, MAX_RATE 32, eight taps and a 16-bit output shift. With these values a DC gain of 2^15 or 2^6 turns into readable output numbers, and exact half-LSB ties can be produced at rate 4. Full-scale input at rate 32 fills the 31-bit integrators, so wrap-around runs continuously over thousands of samples. Coefficients of 100000 overflow the 24-bit output in both directions, which exercises both saturation limits.

// File: rtl/lpdec_pkg.sv
package lpdec_pkg;
  function automatic int growth_bits(input int order, input int max_rate);
    return order * $clog2(max_rate);
  endfunction
endpackage

// File: rtl/sinc_decimator.sv
module sinc_decimator #(
  parameter int IN_W     = 16,
  parameter int ORDER    = 4,
  parameter int MAX_RATE = 8192,
  parameter int RATE_W   = $clog2(MAX_RATE) + 1,
  parameter int ACC_W    = IN_W + lpdec_pkg::growth_bits(ORDER, MAX_RATE)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic [RATE_W-1:0]       rate_i,
  input  logic                    in_valid_i,
  input  logic signed [IN_W-1:0]  in_data_i,
  output logic                    out_valid_o,
  output logic signed [ACC_W-1:0] out_data_o
);
  logic signed [ACC_W-1:0] integ [ORDER];
  logic signed [ACC_W-1:0] dly   [ORDER];
  logic signed [ACC_W-1:0] stage [ORDER+1];
  logic signed [ACC_W-1:0] dec_sample;
  logic signed [ACC_W-1:0] in_ext;
  logic [RATE_W-1:0]       cnt;
  logic                    dec_v;

  assign in_ext = {{(ACC_W-IN_W){in_data_i[IN_W-1]}}, in_data_i};

  // integrators: free-running modulo 2^ACC_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ORDER; i++) integ[i] <= '0;
      cnt        <= '0;
      dec_v      <= 1'b0;
      dec_sample <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < ORDER; i++) integ[i] <= '0;
      cnt        <= '0;
      dec_v      <= 1'b0;
      dec_sample <= '0;
    end else begin
      dec_v <= 1'b0;
      if (in_valid_i) begin
        integ[0] <= integ[0] + in_ext;
        for (int i = 1; i < ORDER; i++) integ[i] <= integ[i] + integ[i-1];
        if (cnt >= rate_i - RATE_W'(1)) begin
          cnt        <= '0;
          dec_v      <= 1'b1;
          dec_sample <= integ[ORDER-1];
        end else begin
          cnt <= cnt + RATE_W'(1);
        end
      end
    end
  end

  // comb chain at the decimated rate
  assign stage[0] = dec_sample;
  for (genvar g = 0; g < ORDER; g++) begin : g_comb
    assign stage[g+1] = stage[g] - dly[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ORDER; i++) dly[i] <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < ORDER; i++) dly[i] <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= dec_v;
      if (dec_v) begin
        for (int i = 0; i < ORDER; i++) dly[i] <= stage[i];
        out_data_o <= stage[ORDER];
      end
    end
  end
endmodule

// File: rtl/sym_fir_decimator.sv
module sym_fir_decimator #(
  parameter int DATA_W = 32,
  parameter int COEF_W = 20,
  parameter int TAPS   = 16,
  parameter int HALF   = TAPS / 2,
  parameter int ADDR_W = $clog2(HALF),
  parameter int ACC_W  = DATA_W + 1 + COEF_W + $clog2(HALF)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     coef_we_i,
  input  logic [ADDR_W-1:0]        coef_addr_i,
  input  logic [COEF_W-1:0]        coef_data_i,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_data_i,
  output logic                     out_valid_o,
  output logic signed [ACC_W-1:0]  out_data_o
);
  localparam int PRE_W  = DATA_W + 1;
  localparam int PROD_W = PRE_W + COEF_W;

  logic [HALF-1:0][COEF_W-1:0] coef_shadow;
  logic [HALF-1:0][COEF_W-1:0] coef_act;
  logic signed [DATA_W-1:0]    dl   [TAPS];
  logic signed [PRE_W-1:0]     pre  [HALF];
  logic signed [PROD_W-1:0]    prod [HALF];
  logic signed [ACC_W-1:0]     sum;
  logic                        idle, phase, go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coef_shadow <= '0;
    else if (coef_we_i) coef_shadow[coef_addr_i] <= coef_data_i;
  end

  // folded taps: one multiply per mirrored pair
  for (genvar k = 0; k < HALF; k++) begin : g_pair
    assign pre[k]  = {dl[k][DATA_W-1], dl[k]} + {dl[TAPS-1-k][DATA_W-1], dl[TAPS-1-k]};
    assign prod[k] = pre[k] * $signed(coef_act[k]);
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < HALF; k++)
      sum = sum + {{(ACC_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAPS; i++) dl[i] <= '0;
      coef_act    <= '0;
      idle        <= 1'b1;
      phase       <= 1'b0;
      go          <= 1'b0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < TAPS; i++) dl[i] <= '0;
      coef_act    <= coef_shadow;
      idle        <= 1'b1;
      phase       <= 1'b0;
      go          <= 1'b0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      if (idle) coef_act <= coef_shadow;
      go          <= 1'b0;
      out_valid_o <= go;
      if (go) out_data_o <= sum;
      if (in_valid_i) begin
        idle  <= 1'b0;
        dl[0] <= in_data_i;
        for (int i = 1; i < TAPS; i++) dl[i] <= dl[i-1];
        phase <= ~phase;
        go    <= phase;
      end
    end
  end
endmodule

// File: rtl/round_sat.sv
module round_sat #(
  parameter int IN_W  = 64,
  parameter int OUT_W = 24,
  parameter int SHIFT = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    in_valid_i,
  input  logic signed [IN_W-1:0]  in_data_i,
  output logic                    out_valid_o,
  output logic signed [OUT_W-1:0] out_data_o
);
  localparam logic signed [IN_W:0] HALF_LSB = (IN_W+1)'(1) << (SHIFT - 1);
  localparam logic signed [IN_W:0] MAX_V = {{(IN_W-OUT_W+2){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W:0] MIN_V = {{(IN_W-OUT_W+2){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [IN_W:0]    biased, scaled;
  logic signed [OUT_W-1:0] clamped;

  assign biased = {in_data_i[IN_W-1], in_data_i} + HALF_LSB;
  assign scaled = biased >>> SHIFT;

  always_comb begin
    if (scaled > MAX_V)      clamped = MAX_V[OUT_W-1:0];
    else if (scaled < MIN_V) clamped = MIN_V[OUT_W-1:0];
    else                     clamped = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (flush_i) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_data_o <= clamped;
    end
  end
endmodule

// File: rtl/lp_decimator.sv
module lp_decimator #(
  parameter int IN_W     = 16,
  parameter int COEF_W   = 20,
  parameter int OUT_W    = 24,
  parameter int ORDER    = 4,
  parameter int MAX_RATE = 8192,
  parameter int TAPS     = 16,
  parameter int SHIFT    = 40,
  localparam int RATE_W  = $clog2(MAX_RATE) + 1,
  localparam int ADDR_W  = $clog2(TAPS / 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              coef_we_i,
  input  logic [ADDR_W-1:0] coef_addr_i,
  input  logic [COEF_W-1:0] coef_data_i,
  input  logic              in_valid_i,
  input  logic [IN_W-1:0]   in_data_i,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  out_data_o
);
  localparam int CIC_W = IN_W + lpdec_pkg::growth_bits(ORDER, MAX_RATE);
  localparam int ACC_W = CIC_W + 1 + COEF_W + ADDR_W;

  logic                    cic_v, acc_v;
  logic signed [CIC_W-1:0] cic_d;
  logic signed [ACC_W-1:0] acc;
  logic signed [OUT_W-1:0] res;

  sinc_decimator #(
    .IN_W(IN_W), .ORDER(ORDER), .MAX_RATE(MAX_RATE), .RATE_W(RATE_W), .ACC_W(CIC_W)
  ) u_cic (
    .clk_i, .rst_ni, .flush_i, .rate_i, .in_valid_i,
    .in_data_i  (signed'(in_data_i)),
    .out_valid_o(cic_v),
    .out_data_o (cic_d)
  );

  sym_fir_decimator #(
    .DATA_W(CIC_W), .COEF_W(COEF_W), .TAPS(TAPS), .ACC_W(ACC_W)
  ) u_fir (
    .clk_i, .rst_ni, .flush_i, .coef_we_i, .coef_addr_i, .coef_data_i,
    .in_valid_i (cic_v),
    .in_data_i  (cic_d),
    .out_valid_o(acc_v),
    .out_data_o (acc)
  );

  round_sat #(.IN_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_rnd (
    .clk_i, .rst_ni, .flush_i,
    .in_valid_i (acc_v),
    .in_data_i  (acc),
    .out_valid_o(out_valid_o),
    .out_data_o (res)
  );

  assign out_data_o = res;
endmodule

// File: rtl/lp_decimator_chk.sv
module lp_decimator_chk #(
  parameter int OUT_W = 24,
  parameter int ACC_W = 64,
  parameter int SHIFT = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    flush_i,
  input logic                    in_valid_i,
  input logic                    cic_v,
  input logic                    acc_v,
  input logic signed [ACC_W-1:0] acc,
  input logic                    out_valid_o,
  input logic [OUT_W-1:0]        out_data_o
);
  localparam logic signed [ACC_W-1:0] POS_LIM = (ACC_W'(2**(OUT_W-1)) - ACC_W'(1)) << SHIFT;
  localparam logic signed [ACC_W-1:0] NEG_LIM = -((ACC_W'(2**(OUT_W-1)) + ACC_W'(1)) << SHIFT);
  localparam logic [OUT_W-1:0] MAX_O = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_O = {1'b1, {(OUT_W-1){1'b0}}};

  AST_OUT_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o); // R3

  AST_CIC_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cic_v |-> $past(in_valid_i, 2)); // R11

  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!out_valid_o && out_data_o == '0)); // R7

  AST_SAT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_v && !flush_i && acc >= POS_LIM) |=> (out_valid_o && out_data_o == MAX_O)); // R9

  AST_SAT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_v && !flush_i && acc <= NEG_LIM) |=> (out_valid_o && out_data_o == MIN_O)); // R9
endmodule

bind lp_decimator lp_decimator_chk #(.OUT_W(OUT_W), .ACC_W(ACC_W), .SHIFT(SHIFT)) u_chk (
  .clk_i, .rst_ni, .flush_i, .in_valid_i, .cic_v, .acc_v, .acc, .out_valid_o, .out_data_o
);

// File: tb/tb_lp_decimator.sv
module tb_lp_decimator;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 16, COEF_W = 20, OUT_W = 24;
  localparam int ORDER = 3, MAX_RATE = 32, TAPS = 8, SHIFT = 16;
  localparam int RATE_W = $clog2(MAX_RATE) + 1;
  localparam int ADDR_W = $clog2(TAPS / 2);
  localparam longint MAX_O = (64'sd1 <<< (OUT_W - 1)) - 1;
  localparam longint MIN_O = -(64'sd1 <<< (OUT_W - 1));

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [RATE_W-1:0] rate = RATE_W'(32);
  logic coef_we = 1'b0;
  logic [ADDR_W-1:0] coef_addr = '0;
  logic [COEF_W-1:0] coef_data = '0;
  logic in_valid = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic out_valid;
  logic [OUT_W-1:0] out_data;

  int n_tests = 0, n_fail = 0;
  int out_cnt = 0, pulse_err = 0, cycles = 0;
  longint last_out = 0;
  logic prev_v = 1'b0;
  longint csum = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_decimator #(
    .IN_W(IN_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .ORDER(ORDER),
    .MAX_RATE(MAX_RATE), .TAPS(TAPS), .SHIFT(SHIFT)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .rate_i(rate),
    .coef_we_i(coef_we), .coef_addr_i(coef_addr), .coef_data_i(coef_data),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  always @(negedge clk) begin
    cycles++;
    if (out_valid) begin
      out_cnt++;
      last_out = longint'(signed'(out_data));
      if (prev_v) pulse_err++;
    end
    prev_v = out_valid;
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint expect_dc(input longint x, input longint r, input longint stored_sum);
    longint v, q;
    v = x * r * r * r * 2 * stored_sum;
    q = (v + (64'sd1 <<< (SHIFT - 1))) >>> SHIFT;
    if (q > MAX_O) q = MAX_O;
    if (q < MIN_O) q = MIN_O;
    return q;
  endfunction

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic write_coefs(input int c0, input int c1, input int c2, input int c3);
    int c [4];
    c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3;
    csum = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      coef_we = 1'b1; coef_addr = ADDR_W'(k); coef_data = COEF_W'(c[k]);
      csum += c[k];
    end
    @(negedge clk); coef_we = 1'b0;
  endtask

  task automatic feed(input int x, input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = IN_W'(x);
      if (gaps) begin @(negedge clk); in_valid = 1'b0; end
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic dc_case(input string req, input int x, input int r, input longint ssum);
    rate = RATE_W'(r);
    do_flush();
    feed(x, 40 * 2 * r, 1'b0);
    check(req, $sformatf("dc x=%0d rate=%0d", x, r), last_out, expect_dc(x, r, ssum));
  endtask

  task automatic t_reset();
    check("R1", "out_valid after reset", longint'(out_valid), 0);
    check("R1", "out_data after reset", longint'(out_data), 0);
  endtask

  task automatic t_dc_gain();
    write_coefs(1, 2, 3, 4);
    dc_case("R2", 100, 32, csum);
    dc_case("R2", -5000, 32, csum);
    dc_case("R10", 32767, 32, csum);
    dc_case("R10", -32768, 32, csum);
  endtask

  task automatic t_interval();
    int base;
    rate = RATE_W'(32);
    do_flush();
    base = out_cnt; pulse_err = 0;
    feed(7, 10 * 64, 1'b0);
    check("R3", "outputs per 640 inputs", out_cnt - base, 10);
    check("R3", "back-to-back valid", pulse_err, 0);
  endtask

  task automatic t_gaps();
    int base;
    rate = RATE_W'(32);
    do_flush();
    base = out_cnt;
    feed(100, 40 * 64, 1'b1);
    check("R11", "outputs with gaps", out_cnt - base, 40);
    check("R11", "value with gaps", last_out, expect_dc(100, 32, csum));
  endtask

  task automatic t_rate();
    int base;
    rate = RATE_W'(4);
    do_flush();
    base = out_cnt;
    feed(1000, 40 * 8, 1'b0);
    check("R4", "outputs at rate 4", out_cnt - base, 40);
    check("R4", "value at rate 4", last_out, expect_dc(1000, 4, csum));
  endtask

  task automatic t_symmetry();
    write_coefs(0, 0, 0, 1);
    dc_case("R5", 100, 32, 1);
    write_coefs(3, 0, 0, 0);
    dc_case("R5", 100, 32, 3);
  endtask

  task automatic t_round();
    write_coefs(1, 0, 0, 0);
    dc_case("R8", 256, 4, 1);   // +0.5 -> 1
    check("R8", "tie +0.5", last_out, 1);
    dc_case("R8", -256, 4, 1);  // -0.5 -> 0
    check("R8", "tie -0.5", last_out, 0);
    dc_case("R8", -768, 4, 1);  // -1.5 -> -1
    check("R8", "tie -1.5", last_out, -1);
  endtask

  task automatic t_sat();
    write_coefs(100000, 100000, 100000, 100000);
    dc_case("R9", 32767, 32, csum);
    check("R9", "positive clamp", last_out, MAX_O);
    dc_case("R9", -32768, 32, csum);
    check("R9", "negative clamp", last_out, MIN_O);
  endtask

  task automatic t_coef_update();
    write_coefs(1, 2, 3, 4);
    rate = RATE_W'(32);
    do_flush();
    feed(100, 20 * 64, 1'b0);
    @(negedge clk); coef_we = 1'b1; coef_addr = '0; coef_data = COEF_W'(500);
    @(negedge clk); coef_we = 1'b0;
    feed(100, 20 * 64, 1'b0);
    check("R6", "write while running ignored", last_out, expect_dc(100, 32, 10));
    do_flush();
    check("R7", "out_data after flush", longint'(out_data), 0);
    check("R7", "out_valid after flush", longint'(out_valid), 0);
    feed(100, 40 * 64, 1'b0);
    check("R7", "new coefs after flush", last_out, expect_dc(100, 32, 509));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dc_gain();
    t_interval();
    t_gaps();
    t_rate();
    t_symmetry();
    t_round();
    t_sat();
    t_coef_update();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule